// File: doc/BRIEF.md
# Scaling-List Inverse Quantizer for 4x4 Blocks

This block turns quantized transform levels of a 4x4 residual block back into coefficients for the inverse transform stage. Each accepted level is multiplied by a position weight and a QP-dependent level scale, shifted left by QP/6, and rounded. It is then shifted right by an amount set by the bit depth and clipped to a signed 16-bit result. One coefficient enters per cycle with its row and column, and the result leaves one cycle later with a valid flag.

The weight comes from one of three modes held in a small control register: a flat weight, the default 4x4 list, or a custom table of sixteen 8-bit weights. The custom table is loaded through a simple write port. For a 4x4 block, larger QP means a larger step, about 12% per QP increment. With a custom list, high-frequency positions can be given larger weights.

Top module: `sl_dequant`

## Requirements
- R1: After reset is asserted, out_valid_o is 0, coeff_o is 0, the weight mode is flat, and every custom weight is 16.
- R2: out_valid_o equals in_valid_i delayed by exactly one clock. coeff_o changes only in the cycle after an accepted input and otherwise holds its value.
- R3: The result is clip((level * w * g[QP%6] * 2^(QP/6) + offset) >> shift), where g = {40,45,51,57,64,72} is indexed by QP%6. The product is formed wide enough that no intermediate overflow occurs for any legal input.
- R4: shift = B - 3 (log2 size 2, minus 5, plus bit depth B), and offset = 2^(shift-1). Bit depth values below 4 are treated as 4.
- R5: The pre-clip result saturates to the range -32768 to 32767.
- R6: QP values above 51 give the same result as QP 51.
- R7: A write with mode_wr_i selects the weight source by mode_i: 0 flat weight 16, 1 default 4x4 list (16 at every position), 2 custom table, 3 behaves as flat.
- R8: A write with wt_we_i stores wt_data_i as the custom weight at index row*4+col, given by wt_addr_i. Custom weights affect results only in custom mode, and a weight of 0 gives result 0.
- R9: The right shift is arithmetic, so negative results round toward minus infinity after the offset is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Level input valid |
| level_i | input | 16 | Signed quantized level |
| row_i | input | 2 | Coefficient row |
| col_i | input | 2 | Coefficient column |
| qp_i | input | 6 | Quantization parameter |
| bit_depth_i | input | 4 | Video bit depth |
| mode_wr_i | input | 1 | Weight-mode register write strobe |
| mode_i | input | 2 | Weight mode written on mode_wr_i |
| wt_we_i | input | 1 | Custom weight write strobe |
| wt_addr_i | input | 4 | Custom weight index, row*4+col |
| wt_data_i | input | 8 | Custom weight value, unsigned |
| out_valid_o | output | 1 | Coefficient valid |
| coeff_o | output | 16 | Signed rescaled coefficient |

## Verification
A set of ten levels is run through every QP from 0 to 55 and several bit depths in flat mode. The set includes zero, small values of both signs and both extremes. This separates errors in the g table and the QP/6 shift, in rounding of negative values, in clamping of QP and bit depth, and in saturation at either rail. A ramp of custom weights from 0 to 255 is then loaded. It is read back in flat, default and reserved modes, where it must have no effect, and in custom mode at every position, which exposes address swaps between row and column. Gaps in in_valid_i show whether the output holds its value and whether the valid flag has the right delay.

// File: rtl/sl_dequant_pkg.sv
package sl_dequant_pkg;
  typedef enum logic [1:0] {
    WM_FLAT    = 2'd0,
    WM_DEFAULT = 2'd1,
    WM_CUSTOM  = 2'd2,
    WM_RSVD    = 2'd3
  } wmode_e;

  localparam int unsigned G_W = 7;

  function automatic logic [G_W-1:0] level_scale(input logic [2:0] idx);
    case (idx)
      3'd0:    level_scale = 7'd40;
      3'd1:    level_scale = 7'd45;
      3'd2:    level_scale = 7'd51;
      3'd3:    level_scale = 7'd57;
      3'd4:    level_scale = 7'd64;
      default: level_scale = 7'd72;
    endcase
  endfunction
endpackage

// File: rtl/sl_weight_rf.sv
module sl_weight_rf
  import sl_dequant_pkg::*;
#(
  parameter int unsigned WGT_W   = 8,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned FLAT_W  = 16,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_i,
  input  logic             wt_we_i,
  input  logic [AW-1:0]    wt_addr_i,
  input  logic [WGT_W-1:0] wt_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WGT_W-1:0] weight_o
);
  wmode_e mode_q;
  logic [WGT_W-1:0] rf_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= WM_FLAT;
    else if (mode_wr_i) mode_q <= wmode_e'(mode_i);
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rf_q[i] <= WGT_W'(FLAT_W);
      else if (wt_we_i && wt_addr_i == AW'(i)) rf_q[i] <= wt_data_i;
    end
  end

  // default 4x4 list is flat as well
  always_comb begin
    unique case (mode_q)
      WM_CUSTOM: weight_o = rf_q[rd_addr_i];
      default:   weight_o = WGT_W'(FLAT_W);
    endcase
  end
endmodule

// File: rtl/sl_qp_map.sv
module sl_qp_map
  import sl_dequant_pkg::*;
#(
  parameter int unsigned QP_W   = 6,
  parameter int unsigned QP_MAX = 51,
  parameter int unsigned QS_W   = 4
) (
  input  logic [QP_W-1:0] qp_i,
  output logic [G_W-1:0]  g_o,
  output logic [QS_W-1:0] qshift_o
);
  logic [QP_W-1:0] qp_eff;

  always_comb begin
    qp_eff   = (qp_i > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : qp_i;
    g_o      = level_scale(3'(qp_eff % QP_W'(6)));
    qshift_o = QS_W'(qp_eff / QP_W'(6));
  end
endmodule

// File: rtl/sl_rescale_core.sv
module sl_rescale_core
  import sl_dequant_pkg::*;
#(
  parameter int unsigned LEVEL_W = 16,
  parameter int unsigned WGT_W   = 8,
  parameter int unsigned QS_W    = 4,
  parameter int unsigned SH_W    = 4,
  parameter int unsigned OUT_W   = 16,
  localparam int unsigned ACC_W  = LEVEL_W + WGT_W + G_W + (1 << QS_W) / 2 + 2
) (
  input  logic signed [LEVEL_W-1:0] level_i,
  input  logic [WGT_W-1:0]          weight_i,
  input  logic [G_W-1:0]            g_i,
  input  logic [QS_W-1:0]           qshift_i,
  input  logic [SH_W-1:0]           shift_i,
  output logic signed [OUT_W-1:0]   coeff_o
);
  localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MIN_V = -MAX_V - ACC_W'(1);

  logic signed [ACC_W-1:0] lvl_x, w_x, g_x, prod, scaled, offset, shifted;

  always_comb begin
    lvl_x   = {{(ACC_W-LEVEL_W){level_i[LEVEL_W-1]}}, level_i};
    w_x     = {{(ACC_W-WGT_W){1'b0}}, weight_i};
    g_x     = {{(ACC_W-G_W){1'b0}}, g_i};
    prod    = lvl_x * w_x * g_x;
    scaled  = prod <<< qshift_i;
    offset  = {{(ACC_W-1){1'b0}}, 1'b1} << (shift_i - SH_W'(1));
    shifted = (scaled + offset) >>> shift_i;
    if (shifted > MAX_V)      coeff_o = MAX_V[OUT_W-1:0];
    else if (shifted < MIN_V) coeff_o = MIN_V[OUT_W-1:0];
    else                      coeff_o = shifted[OUT_W-1:0];
  end
endmodule

// File: rtl/sl_dequant.sv
module sl_dequant
  import sl_dequant_pkg::*;
#(
  parameter int unsigned LEVEL_W = 16,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned WGT_W   = 8,
  parameter int unsigned QP_W    = 6,
  parameter int unsigned BD_W    = 4,
  parameter int unsigned BLK     = 4,
  parameter int unsigned BD_MIN  = 4,
  localparam int unsigned POS_W  = $clog2(BLK),
  localparam int unsigned LOG2_N = $clog2(BLK),
  localparam int unsigned ENT    = BLK * BLK,
  localparam int unsigned AW     = $clog2(ENT),
  localparam int unsigned QS_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [POS_W-1:0]   row_i,
  input  logic [POS_W-1:0]   col_i,
  input  logic [QP_W-1:0]    qp_i,
  input  logic [BD_W-1:0]    bit_depth_i,
  input  logic               mode_wr_i,
  input  logic [1:0]         mode_i,
  input  logic               wt_we_i,
  input  logic [AW-1:0]      wt_addr_i,
  input  logic [WGT_W-1:0]   wt_data_i,
  output logic               out_valid_o,
  output logic [OUT_W-1:0]   coeff_o
);
  logic [WGT_W-1:0] weight;
  logic [G_W-1:0]   g;
  logic [QS_W-1:0]  qshift;
  logic [BD_W-1:0]  bd_eff, shift1;
  logic [OUT_W-1:0] coeff_d;

  sl_weight_rf #(.WGT_W(WGT_W), .ENTRIES(ENT), .FLAT_W(16)) u_wrf (
    .clk_i, .rst_ni, .mode_wr_i, .mode_i, .wt_we_i, .wt_addr_i, .wt_data_i,
    .rd_addr_i({row_i, col_i}), .weight_o(weight)
  );

  sl_qp_map #(.QP_W(QP_W), .QP_MAX(51), .QS_W(QS_W)) u_qpm (
    .qp_i, .g_o(g), .qshift_o(qshift)
  );

  // shift1 = log2(N) - 5 + bit depth
  always_comb begin
    bd_eff = (bit_depth_i < BD_W'(BD_MIN)) ? BD_W'(BD_MIN) : bit_depth_i;
    shift1 = bd_eff + BD_W'(LOG2_N) - BD_W'(5);
  end

  sl_rescale_core #(
    .LEVEL_W(LEVEL_W), .WGT_W(WGT_W), .QS_W(QS_W), .SH_W(BD_W), .OUT_W(OUT_W)
  ) u_core (
    .level_i, .weight_i(weight), .g_i(g), .qshift_i(qshift), .shift_i(shift1),
    .coeff_o(coeff_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      coeff_o     <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) coeff_o <= coeff_d;
    end
  end
endmodule

// File: rtl/sl_dequant_chk.sv
module sl_dequant_chk #(
  parameter int unsigned LEVEL_W = 16,
  parameter int unsigned OUT_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic [LEVEL_W-1:0] level_i,
  input logic               out_valid_o,
  input logic [OUT_W-1:0]   coeff_o
);
  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  // R2
  coeff_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(coeff_o));
  // R3
  zero_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && level_i == '0) |=> coeff_o == '0);
  // R9
  pos_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !level_i[LEVEL_W-1]) |=> !coeff_o[OUT_W-1]);
  // R9
  neg_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && level_i[LEVEL_W-1]) |=> (coeff_o[OUT_W-1] || coeff_o == '0));
endmodule

bind sl_dequant sl_dequant_chk #(.LEVEL_W(LEVEL_W), .OUT_W(OUT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .level_i(level_i),
  .out_valid_o(out_valid_o), .coeff_o(coeff_o)
);

// File: tb/sl_dequant_tb.sv
module sl_dequant_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] level = '0;
  logic [1:0]  row = '0, col = '0;
  logic [5:0]  qp = '0;
  logic [3:0]  bd = 4'd8;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode = '0;
  logic        wt_we = 1'b0;
  logic [3:0]  wt_addr = '0;
  logic [7:0]  wt_data = '0;
  logic        out_valid;
  logic [15:0] coeff;

  int checks = 0, errors = 0;
  bit done = 0;
  int cur_mode = 0;
  int wtab [16];

  always #2 clk = ~clk;

  sl_dequant dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .level_i(level),
    .row_i(row), .col_i(col), .qp_i(qp), .bit_depth_i(bd),
    .mode_wr_i(mode_wr), .mode_i(mode), .wt_we_i(wt_we), .wt_addr_i(wt_addr),
    .wt_data_i(wt_data), .out_valid_o(out_valid), .coeff_o(coeff)
  );

  function automatic longint ref_val(int lv, int r, int c, int q, int b);
    longint g [6] = '{40, 45, 51, 57, 64, 72};
    longint w, p, res;
    int qe, be, sh;
    qe = (q > 51) ? 51 : q;
    be = (b < 4) ? 4 : b;
    sh = be - 3;
    w  = (cur_mode == 2) ? longint'(wtab[r*4+c]) : 64'sd16;
    p  = longint'(lv) * w * g[qe % 6] * (64'sd1 << (qe / 6));
    res = (p + (64'sd1 <<< (sh - 1))) >>> sh;
    if (res > 32767) res = 32767;
    if (res < -32768) res = -32768;
    return res;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_one(string req, int lv, int r, int c, int q, int b);
    @(negedge clk);
    in_valid = 1'b1; level = 16'(lv); row = 2'(r); col = 2'(c);
    qp = 6'(q); bd = 4'(b);
    @(posedge clk); #1;
    check(req, longint'($signed(coeff)), ref_val(lv, r, c, q, b));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_mode(int m);
    @(negedge clk);
    mode_wr = 1'b1; mode = 2'(m);
    @(negedge clk);
    mode_wr = 1'b0;
    cur_mode = (m == 2) ? 2 : 0;
  endtask

  task automatic write_wt(int a, int d);
    @(negedge clk);
    wt_we = 1'b1; wt_addr = 4'(a); wt_data = 8'(d);
    @(negedge clk);
    wt_we = 1'b0;
    wtab[a] = d;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int lv_set [10] = '{0, 1, -1, 7, -7, 100, -100, 12345, 32767, -32768};
    int bd_set [5]  = '{3, 4, 8, 10, 12};
    int lv_c [5]    = '{1, -1, 300, -300, 32767};
    int qp_c [3]    = '{0, 17, 51};
    logic [15:0] held;
    for (int i = 0; i < 16; i++) wtab[i] = 16;

    #7;
    // R1 reset state
    check("R1 valid", out_valid, 0);
    check("R1 coeff", coeff, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 flat mode after reset, R3 R4 R5 R6 R9 sweep
    for (int q = 0; q < 56; q++)
      for (int b = 0; b < 5; b++)
        for (int k = 0; k < 10; k++)
          run_one("R3/R4/R5/R6/R9 flat sweep", lv_set[k], k % 4, (k + q) % 4, q, bd_set[b]);

    // R5 explicit rails
    run_one("R5 upper rail", 32767, 3, 3, 51, 4);
    check("R5 upper value", longint'($signed(coeff)), 32767);
    run_one("R5 lower rail", -32768, 0, 0, 51, 4);
    check("R5 lower value", longint'($signed(coeff)), -32768);
    // R9 floor of negative: -1*16*40=-640, +16 >>5 = -20 ; -3: -1920+16=-1904>>5=-60 (floor -59.5)
    run_one("R9 negative rounding", -3, 1, 2, 0, 8);
    check("R9 negative value", longint'($signed(coeff)), -60);

    // R2 hold and valid timing
    @(negedge clk);
    held = coeff;
    in_valid = 1'b0; level = 16'd999;
    @(posedge clk); #1;
    check("R2 valid low", out_valid, 0);
    check("R2 coeff held", coeff, held);
    @(negedge clk);
    in_valid = 1'b1; level = 16'd5; qp = 6'd0; bd = 4'd8;
    @(posedge clk); #1;
    check("R2 valid high", out_valid, 1);
    @(negedge clk);
    in_valid = 1'b0;

    // R8 writes ignored outside custom mode
    for (int a = 0; a < 16; a++) write_wt(a, (a * 17) & 8'hFF);
    for (int m = 0; m < 4; m++) begin
      if (m != 2) begin
        set_mode(m);
        for (int p = 0; p < 16; p++)
          run_one("R7/R8 non-custom mode flat weight", 100, p / 4, p % 4, 20, 8);
      end
    end

    // R7 R8 custom mode, index row*4+col
    set_mode(2);
    for (int p = 0; p < 16; p++)
      for (int qi = 0; qi < 3; qi++)
        for (int li = 0; li < 5; li++)
          run_one("R8 custom weights", lv_c[li], p / 4, p % 4, qp_c[qi], 8);
    run_one("R8 zero weight", 32767, 0, 0, 51, 8);
    check("R8 zero weight value", longint'($signed(coeff)), 0);

    // R7 return to default list
    set_mode(1);
    run_one("R7 default list", 1000, 3, 3, 30, 10);

    finish_up();
  end
endmodule